// File: doc/BRIEF.md
# Sequential Booth BPSK Sample Generator

This block turns a serial bit stream into a stream of signed BPSK samples. An internal five-bit phase index walks through a sine table with 32 entries. Each 8-bit carrier value is multiplied by a bipolar level taken from the current data bit. A data bit of 0 gives +1 and leaves the carrier as it is. A data bit of 1 gives -1 and turns the carrier by 180 degrees. The multiplication is done one step at a time by a radix-2 Booth shift-add datapath, not by an array multiplier.

A new data bit is offered on `bit_in` together with a one-cycle `bit_stb`. The bit is held in a pending register. It replaces the active bit only when the phase index is back at 0, so every bit spans a whole number of carrier periods and the carrier is never restarted part way through. Each product is shown on `sample_out` together with a one-cycle `sample_valid`.

The control is a three-state machine:
- LOAD: fetch the carrier sample, fix the bipolar operand and clear the accumulator. Its transition LOAD→STEP is always taken.
- STEP: one Booth iteration per cycle. The transition STEP→STEP repeats until the multiplier-width count is reached, then STEP→EMIT.
- EMIT: present the product with `sample_valid` high and advance the phase index. The transition EMIT→LOAD is always taken.

Top module: `bpsk_booth_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the state machine, the phase index, the accumulator and the pending and active bits are cleared, and `sample_valid` stays low. The first sample after reset uses carrier index 0 with the active bit equal to 0.
- R2: With active bit 0, `sample_out` equals the carrier value. With active bit 1, `sample_out` equals its negation. Both are 10-bit two's complement values, using operand encodings +1 = 2'b01 and -1 = 2'b11.
- R3: `sample_valid` is high for exactly one cycle per sample. The first pulse follows the third rising edge after `rst` is released, and the pulses then repeat every 4 cycles (multiplier width plus 2).
- R4: The carrier index steps by one after each sample and wraps from 31 to 0. Entry i holds 127·sin(2πi/32) rounded to the nearest integer, so every value lies within ±127.
- R5: A strobed bit becomes active only at the load of carrier index 0. A strobe on the very edge that loads index 0 is kept for the following period.
- R6: When several strobes arrive before one index-0 load, the bit of the last strobe is the one used.
- R7: `bit_in` without `bit_stb` changes neither the pending bit nor any output.
- R8: Each Booth step examines the pair {multiplier LSB, previous bit}. On 10 it subtracts the carrier from the accumulator, on 01 it adds it, and on 00 or 11 it leaves it unchanged. After that it arithmetic-shifts the whole product right by one. The magnitude of every product equals the magnitude of its carrier sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_stb | input | 1 | One-cycle strobe that captures `bit_in` |
| sample_out | output | 10 | Signed modulated sample |
| sample_valid | output | 1 | One-cycle flag marking a new sample |

## Verification
A sample is due on the third rising edge after reset release and on every fourth edge after that. The bench counts edges from release and samples the outputs 1 ns after each edge. It expects `sample_valid` high only on those counts and low on all others. The carrier index of the sample due on edge n is ((n-3)/4) mod 32. The bit it carries is the one that was active at the LOAD edge two cycles earlier. The bench's model fixes that bit on edges where n mod 4 equals 1, and only swaps in the pending bit when the index is 0. Expected carrier values come from floating-point sine arithmetic, not from any integer table.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_STEP = 2'd1,
        ST_EMIT = 2'd2
    } mod_state_t;

    // First-quadrant magnitudes, 127*sin(k*pi/16) rounded, k = 0..8
    function automatic logic [6:0] quarter_sine(input logic [3:0] k);
        logic [6:0] v;
        unique case (k)
            4'd0:    v = 7'd0;
            4'd1:    v = 7'd25;
            4'd2:    v = 7'd49;
            4'd3:    v = 7'd71;
            4'd4:    v = 7'd90;
            4'd5:    v = 7'd106;
            4'd6:    v = 7'd117;
            4'd7:    v = 7'd125;
            default: v = 7'd127;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bpsk_carrier_rom.sv
module bpsk_carrier_rom #(
    parameter int PH_W = 5,
    parameter int CW   = 8
) (
    input  logic [PH_W-1:0]       phase,
    output logic signed [CW-1:0]  carrier
);
    import bpsk_pkg::*;

    localparam int QB = PH_W - 2;

    logic [1:0]    quadrant;
    logic [QB-1:0] offset;
    logic [QB:0]   qidx;
    logic [6:0]    mag;
    logic signed [CW-1:0] mag_ext;

    assign quadrant = phase[PH_W-1:PH_W-2];
    assign offset   = phase[QB-1:0];

    // Mirror the offset in the second and fourth quadrants
    always_comb begin
        if (quadrant[0])
            qidx = (QB+1)'(1 << QB) - {1'b0, offset};
        else
            qidx = {1'b0, offset};
    end

    assign mag     = quarter_sine(4'(qidx));
    assign mag_ext = CW'({1'b0, mag});
    // Lower half of the period is negative
    assign carrier = quadrant[1] ? -mag_ext : mag_ext;

endmodule

// File: rtl/bpsk_bit_gate.sv
module bpsk_bit_gate #(
    parameter int NW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_in,
    input  logic          bit_stb,
    input  logic          take,
    output logic [NW-1:0] nrz
);
    logic pend_bit;
    logic pend_vld;
    logic cur_bit;
    logic eff_bit;

    assign eff_bit = (take && pend_vld) ? pend_bit : cur_bit;
    // Bipolar level: 0 -> +1, 1 -> -1 (all ones)
    assign nrz = eff_bit ? {NW{1'b1}} : NW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_bit <= 1'b0;
            pend_vld <= 1'b0;
            cur_bit  <= 1'b0;
        end else begin
            if (take && pend_vld)
                cur_bit <= pend_bit;
            if (bit_stb) begin
                pend_bit <= bit_in;
                pend_vld <= 1'b1;
            end else if (take) begin
                pend_vld <= 1'b0;
            end
        end
    end

    // The active bit switches only on a period-boundary load
    p_bit_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_bit != $past(cur_bit)) |-> $past(take));

    // Without a strobe the pending bit keeps its value
    p_hold_without_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(pend_bit));

endmodule

// File: rtl/bpsk_booth_dp.sv
module bpsk_booth_dp #(
    parameter int CW = 8,
    parameter int NW = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    step,
    input  logic signed [CW-1:0]    mcand,
    input  logic [NW-1:0]           mplier,
    output logic signed [CW-1:0]    mcand_q,
    output logic signed [CW+NW-1:0] product
);
    logic signed [CW-1:0] acc;
    logic signed [CW-1:0] sum;
    logic [NW-1:0]        mq;
    logic                 qm1;
    logic [1:0]           pair;

    assign pair = {mq[0], qm1};

    always_comb begin
        unique case (pair)
            2'b10:   sum = acc - mcand_q;
            2'b01:   sum = acc + mcand_q;
            default: sum = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            mq      <= '0;
            qm1     <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc     <= '0;
            mq      <= mplier;
            qm1     <= 1'b0;
            mcand_q <= mcand;
        end else if (step) begin
            acc <= {sum[CW-1], sum[CW-1:1]};
            mq  <= {sum[0], mq[NW-1:1]};
            qm1 <= mq[0];
        end
    end

    assign product = {acc, mq};

endmodule

// File: rtl/bpsk_booth_mod.sv
module bpsk_booth_mod #(
    parameter int CW   = 8,
    parameter int NW   = 2,
    parameter int PH_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    input  logic                    bit_stb,
    output logic signed [CW+NW-1:0] sample_out,
    output logic                    sample_valid
);
    import bpsk_pkg::*;

    localparam int PW    = CW + NW;
    localparam int CNT_W = $clog2(NW + 1);

    mod_state_t         state, state_nxt;
    logic [CNT_W-1:0]   cnt, cnt_nxt;
    logic [PH_W-1:0]    phase;
    logic               do_load, do_step, take;
    logic signed [CW-1:0] carrier, mcand_q;
    logic [NW-1:0]      nrz;
    logic signed [PW-1:0] product;

    bpsk_carrier_rom #(.PH_W(PH_W), .CW(CW)) u_rom (
        .phase   (phase),
        .carrier (carrier)
    );

    bpsk_bit_gate #(.NW(NW)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_stb (bit_stb),
        .take    (take),
        .nrz     (nrz)
    );

    bpsk_booth_dp #(.CW(CW), .NW(NW)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .load    (do_load),
        .step    (do_step),
        .mcand   (carrier),
        .mplier  (nrz),
        .mcand_q (mcand_q),
        .product (product)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_LOAD: begin
                state_nxt = ST_STEP;
                cnt_nxt   = '0;
            end
            ST_STEP: begin
                cnt_nxt = cnt + 1'b1;
                if (cnt == CNT_W'(NW - 1))
                    state_nxt = ST_EMIT;
            end
            ST_EMIT: state_nxt = ST_LOAD;
            default: state_nxt = ST_LOAD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOAD;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (state == ST_EMIT)
            phase <= phase + 1'b1;
    end

    // Outputs
    always_comb begin
        do_load      = (state == ST_LOAD);
        do_step      = (state == ST_STEP);
        take         = (state == ST_LOAD) && (phase == '0);
        sample_valid = (state == ST_EMIT);
        sample_out   = product;
    end

    // Checker state: cycles since the previous valid pulse
    logic [3:0] gap;
    logic       seen;
    logic signed [PW-1:0] mc_ext;
    assign mc_ext = PW'(mcand_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (sample_valid) begin
            gap  <= 4'd1;
            seen <= 1'b1;
        end else if (gap != 4'hF) begin
            gap <= gap + 1'b1;
        end
    end

    p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    p_valid_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && seen) |-> (gap == 4'(NW + 2)));

    p_phase_step_r4: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> (phase == PH_W'($past(phase) + 1'b1)));

    p_product_mag_r8: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> ((sample_out == mc_ext) || (sample_out == -mc_ext)));

endmodule

// File: tb/tb_bpsk_booth_mod.sv
`timescale 1ns/1ps
module tb_bpsk_booth_mod;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_stb = 1'b0;
    logic signed [9:0] sample_out;
    logic sample_valid;

    always #4 clk = ~clk;

    bpsk_booth_mod dut (
        .clk          (clk),
        .rst          (rst),
        .bit_in       (bit_in),
        .bit_stb      (bit_stb),
        .sample_out   (sample_out),
        .sample_valid (sample_valid)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    // Reference model state
    int n = 0;
    bit m_cur = 0, m_pend = 0, m_pvld = 0, m_used = 0;

    function automatic int carrier_ref(int ph);
        real v;
        v = 127.0 * $sin(2.0 * 3.141592653589793 * ph / 32.0);
        return int'(v);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // One clock edge with the given inputs, then compare with the model
    task automatic tick(bit stb, bit b);
        bit exp_v;
        int k, e;
        bit_stb = stb;
        bit_in  = b;
        @(posedge clk);
        n++;
        if (n % 4 == 1) begin
            k = (n - 1) / 4;
            if ((k % 32 == 0) && m_pvld) begin
                m_cur  = m_pend;
                m_pvld = 0;
            end
            m_used = m_cur;
        end
        if (stb) begin
            m_pend = b;
            m_pvld = 1;
        end
        #1;
        exp_v = (n % 4 == 3);
        check(sample_valid == exp_v, "R3", int'(sample_valid), int'(exp_v));
        if (exp_v) begin
            k = (n - 3) / 4;
            e = m_used ? -carrier_ref(k % 32) : carrier_ref(k % 32);
            check(sample_out == e, tag, int'(sample_out), e);
        end
    endtask

    // Idle edges; bit_in toggles without a strobe (R7)
    task automatic idle(int c);
        for (int i = 0; i < c; i++) tick(1'b0, i[0]);
    endtask

    task automatic run_to(int target);
        while (n < target) tick(1'b0, n[1]);
    endtask

    task automatic do_reset();
        bit_stb = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(sample_valid == 1'b0, "R1", int'(sample_valid), 0);
        n = 0; m_cur = 0; m_pend = 0; m_pvld = 0; m_used = 0;
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state and first sample at index 0, bit 0
        do_reset();
        tag = "R1";
        idle(4);
        // R2, R4, R7: full period of bit 0 with bit_in toggling unstrobed
        tag = "R4";
        run_to(128);
        // R5: strobe mid-period; current period must stay unchanged
        tag = "R5";
        idle(60);
        tick(1'b1, 1'b1);
        run_to(256);
        // R2: period carried by bit 1 (negated carrier)
        tag = "R2";
        idle(30);
        // R6: two strobes, last (1) wins
        tick(1'b1, 1'b0);
        idle(17);
        tick(1'b1, 1'b1);
        run_to(384);
        tag = "R6";
        idle(40);
        tick(1'b1, 1'b1);
        idle(9);
        tick(1'b1, 1'b0);
        run_to(640);
        // R5: strobe on the very edge that loads index 0
        tag = "R5";
        tick(1'b1, 1'b1);
        run_to(896);
        // R8: magnitude preserved over a period of each sign
        tag = "R8";
        run_to(1024);
        // R1: mid-run reset returns to index 0 with bit 0
        idle(50);
        do_reset();
        tag = "R1";
        idle(12);
        tag = "R7";
        run_to(200);
        summary();
        $finish;
    end

endmodule